// File: doc/BRIEF.md
# Streaming CRC-32 over a 64-bit beat bus

This block computes the common reflected 32-bit frame check sequence (the one used by Ethernet and ZIP archives) over a frame that arrives eight bytes per clock. Every beat, whatever its byte count, goes through one 64-bit-wide XOR update network. No narrower engine sits beside it for short beats.

A frame whose length is not a multiple of eight carries its short part in its first beat. The message bytes sit in the upper lanes of that beat, and the lanes below them count as leading zero bytes. The running state starts each frame at zero, so those leading zeros leave it untouched. The standard all-ones start is folded in by inverting the first four message bytes as they pass. Frames shorter than four bytes get a small length-dependent correction at the end, and a fixed constant is applied last. The result and a one-cycle done strobe appear on the cycle after the closing beat is taken. A new frame may begin on the very next beat.

A beat whose lane-enable pattern breaks the placement rule drops the frame and raises a one-cycle error pulse.

Top module: `crc64_stream`

## Requirements
- R1: While reset is held and right after it, `crc_o` is 0 and both `crc_done_o` and `frame_err_o` are 0.
- R2: For a frame of N bytes, `crc_o` equals the standard CRC-32 of those bytes: reflected polynomial 0xEDB88320, all-ones start, complemented result. Bytes are taken in order, lane 0 (bits 7:0) before lane 7 within a beat, bit 0 of each byte first, and beats in order. The nine ASCII bytes "123456789" give 0xCBF43926.
- R3: A first beat carrying r < 8 bytes has lane enables set on lanes 8-r through 7 only (mask 0xFF shifted left by 8-r). Message byte 0 is in lane 8-r. The data on disabled lanes has no effect on the result.
- R4: Frames of 1, 2 and 3 bytes give the correct CRC.
- R5: `crc_done_o` is high for exactly the cycle after the beat with `beat_eof_i` is accepted, and `crc_o` changes only on that cycle.
- R6: A beat with `beat_sof_i` may follow an end beat on the next cycle. A start beat in the middle of a frame discards the open frame and starts a new one.
- R7: A start beat whose lane enables are zero, are not contiguous, or do not include lane 7 raises `frame_err_o` for one cycle, produces no done, and leaves no frame open.
- R8: A non-start beat whose lane enables are not all ones raises `frame_err_o` for one cycle, and the frame is dropped with no done.
- R9: A valid beat without `beat_sof_i` while no frame is open is ignored: no done and no error. Cycles with `beat_valid_i` low inside a frame do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| beat_valid_i | input | 1 | A beat is presented this cycle |
| beat_sof_i | input | 1 | This beat opens a frame |
| beat_eof_i | input | 1 | This beat closes the frame |
| beat_data_i | input | 64 | Beat data, lane k in bits 8k+7:8k |
| beat_lane_en_i | input | 8 | Per-lane byte enable |
| crc_o | output | 32 | Result of the last completed frame |
| crc_done_o | output | 1 | One-cycle strobe, new result on `crc_o` |
| frame_err_o | output | 1 | One-cycle strobe, lane-enable rule broken |

## Verification
The hardest case to reach is a frame whose first four message bytes straddle two beats. In that case the inversion of the start bytes has to carry over from a first beat holding one to three bytes into the lanes at the bottom of the next beat. The table of lengths and the random run of lengths 1 to 64 include lengths such as 9, 10 and 51, which put one, two or three bytes in the first beat. Idle gaps between beats and junk data in the disabled lanes are added so that the carried state must survive both.

// File: rtl/crc64_pkg.sv
package crc64_pkg;

    localparam int CRC_W     = 32;
    localparam int BYTE_W    = 8;
    localparam int PRE_BYTES = CRC_W / BYTE_W;

    typedef logic [CRC_W-1:0] crc_t;

endpackage

// File: rtl/crc64_xor_net.sv
module crc64_xor_net
    import crc64_pkg::*;
#(
    parameter int   DATA_W = 64,
    parameter crc_t POLY   = 32'hEDB88320
) (
    input  crc_t              state_i,
    input  logic [DATA_W-1:0] data_i,
    output crc_t              state_o
);

    localparam int IN_W = CRC_W + DATA_W;

    // Column j of the update matrix: which state and data bits feed output bit j.
    function automatic logic [IN_W-1:0] tap_column(input int j);
        logic [IN_W-1:0]   col;
        crc_t              c;
        logic [DATA_W-1:0] d;
        logic              fb;
        col = '0;
        for (int k = 0; k < IN_W; k++) begin
            c = '0;
            d = '0;
            if (k < CRC_W) c[k] = 1'b1;
            else           d[k-CRC_W] = 1'b1;
            for (int b = 0; b < DATA_W; b++) begin
                fb = c[0] ^ d[b];
                c  = c >> 1;
                if (fb) c = c ^ POLY;
            end
            col[k] = c[j];
        end
        return col;
    endfunction

    logic [IN_W-1:0] vec;
    assign vec = {data_i, state_i};

    for (genvar j = 0; j < CRC_W; j++) begin : g_bit
        localparam logic [IN_W-1:0] TAPS = tap_column(j);
        assign state_o[j] = ^(vec & TAPS);
    end

endmodule

// File: rtl/crc64_lane_prep.sv
module crc64_lane_prep
    import crc64_pkg::*;
#(
    parameter int LANES = 8,
    localparam int DATA_W = LANES * BYTE_W,
    localparam int CNT_W  = $clog2(LANES + 1)
) (
    input  logic              first_i,
    input  logic [LANES-1:0]  en_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  inv_left_i,
    output logic [DATA_W-1:0] data_o,
    output logic              mask_ok_o,
    output logic [CNT_W-1:0]  count_o
);

    logic [LANES-1:0] off;
    logic             top_run;
    logic [CNT_W-1:0] lo;

    always_comb begin
        off       = ~en_i;
        // enabled lanes must form one run ending at the top lane
        top_run   = (en_i != '0) && ((off & (off + LANES'(1))) == '0);
        mask_ok_o = first_i ? top_run : (en_i == '1);
        count_o   = CNT_W'($countones(en_i));
        lo        = CNT_W'(LANES) - count_o;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [CNT_W-1:0] rel;
        logic             inv;
        assign rel = CNT_W'(l) - lo;
        assign inv = en_i[l] && (CNT_W'(l) >= lo) && (rel < inv_left_i);
        assign data_o[l*BYTE_W +: BYTE_W] =
            en_i[l] ? (data_i[l*BYTE_W +: BYTE_W] ^ {BYTE_W{inv}}) : '0;
    end

endmodule

// File: rtl/crc64_finalize.sv
module crc64_finalize
    import crc64_pkg::*;
#(
    parameter crc_t FINAL_XOR = 32'hFFFFFFFF,
    parameter int   CNT_W     = 4
) (
    input  crc_t             state_i,
    input  logic [CNT_W-1:0] seen_i,
    output crc_t             crc_o
);

    crc_t fix;

    always_comb begin
        // frames shorter than the register lose part of the all-ones start
        if (seen_i < CNT_W'(PRE_BYTES)) fix = '1 >> (BYTE_W * int'(seen_i));
        else                            fix = '0;
        crc_o = state_i ^ FINAL_XOR ^ fix;
    end

endmodule

// File: rtl/crc64_stream.sv
module crc64_stream
    import crc64_pkg::*;
#(
    parameter int   LANES     = 8,
    parameter crc_t POLY      = 32'hEDB88320,
    parameter crc_t FINAL_XOR = 32'hFFFFFFFF,
    localparam int  DATA_W    = LANES * BYTE_W,
    localparam int  CNT_W     = $clog2(LANES + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              beat_valid_i,
    input  logic              beat_sof_i,
    input  logic              beat_eof_i,
    input  logic [DATA_W-1:0] beat_data_i,
    input  logic [LANES-1:0]  beat_lane_en_i,
    output crc_t              crc_o,
    output logic              crc_done_o,
    output logic              frame_err_o
);

    typedef struct packed {
        logic             in_frame;
        logic [CNT_W-1:0] inv_left;
        logic [CNT_W-1:0] seen;
        crc_t             crc;
        crc_t             res;
        logic             done;
        logic             err;
    } st_t;

    st_t st_d, st_q;

    logic [DATA_W-1:0] prep_data;
    logic              mask_ok;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  inv_base;
    logic [CNT_W-1:0]  seen_base;
    logic [CNT_W:0]    seen_sum;
    logic [CNT_W-1:0]  seen_nx;
    logic [CNT_W-1:0]  used;
    crc_t              base_crc;
    crc_t              net_out;
    crc_t              fin_out;
    logic              accept;

    assign inv_base  = beat_sof_i ? CNT_W'(PRE_BYTES) : st_q.inv_left;
    assign seen_base = beat_sof_i ? '0 : st_q.seen;
    assign base_crc  = beat_sof_i ? '0 : st_q.crc;

    crc64_lane_prep #(.LANES(LANES)) i_prep (
        .first_i    (beat_sof_i),
        .en_i       (beat_lane_en_i),
        .data_i     (beat_data_i),
        .inv_left_i (inv_base),
        .data_o     (prep_data),
        .mask_ok_o  (mask_ok),
        .count_o    (count)
    );

    crc64_xor_net #(.DATA_W(DATA_W), .POLY(POLY)) i_net (
        .state_i (base_crc),
        .data_i  (prep_data),
        .state_o (net_out)
    );

    crc64_finalize #(.FINAL_XOR(FINAL_XOR), .CNT_W(CNT_W)) i_fin (
        .state_i (net_out),
        .seen_i  (seen_nx),
        .crc_o   (fin_out)
    );

    always_comb begin
        seen_sum = {1'b0, seen_base} + {1'b0, count};
        seen_nx  = (seen_sum >= (CNT_W+1)'(PRE_BYTES)) ? CNT_W'(PRE_BYTES)
                                                      : seen_sum[CNT_W-1:0];
        used     = (count < inv_base) ? count : inv_base;
        accept   = beat_valid_i && (beat_sof_i || st_q.in_frame);

        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        if (accept) begin
            if (!mask_ok) begin
                st_d.in_frame = 1'b0;
                st_d.err      = 1'b1;
            end else begin
                st_d.crc      = net_out;
                st_d.inv_left = inv_base - used;
                st_d.seen     = seen_nx;
                if (beat_eof_i) begin
                    st_d.in_frame = 1'b0;
                    st_d.done     = 1'b1;
                    st_d.res      = fin_out;
                end else begin
                    st_d.in_frame = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign crc_o       = st_q.res;
    assign crc_done_o  = st_q.done;
    assign frame_err_o = st_q.err;

    AST_DONE_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        crc_done_o |-> $past(beat_valid_i && beat_eof_i)); // R5
    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !crc_done_o |-> $stable(crc_o)); // R5
    AST_ERR_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_err_o |-> !crc_done_o); // R7
    AST_ERR_AFTER_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_err_o |-> $past(beat_valid_i)); // R8
    AST_EMPTY_START_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (beat_valid_i && beat_sof_i && beat_lane_en_i == '0) |=> frame_err_o); // R7
    AST_IDLE_BEAT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (beat_valid_i && !beat_sof_i && !st_q.in_frame) |=> (!crc_done_o && !frame_err_o)); // R9

endmodule

// File: tb/test_crc64_stream.sv
module test_crc64_stream;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        v = 1'b0, sof = 1'b0, eof = 1'b0;
    logic [63:0] data = '0;
    logic [7:0]  en = '0;
    logic [31:0] crc;
    logic        done, err;

    always #5 clk = ~clk;

    crc64_stream i_crc64_stream (
        .clk_i(clk), .rst_ni(rst_n), .beat_valid_i(v), .beat_sof_i(sof),
        .beat_eof_i(eof), .beat_data_i(data), .beat_lane_en_i(en),
        .crc_o(crc), .crc_done_o(done), .frame_err_o(err)
    );

    localparam int NTAB = 16;
    localparam int TAB_LEN  [NTAB] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 14, 16, 17, 51, 64};
    localparam int TAB_SEED [NTAB] = '{3, 5, 7, 11, 13, 17, 19, 23, 29, 31, 37, 41, 43, 47, 53, 59};

    int n_checks = 0, n_fail = 0;
    logic [7:0]  msg [0:63];
    logic        got_done, got_err;
    logic [31:0] got_crc;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        logic fb;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) begin
                fb = c[0] ^ msg[i][b];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        return ~c;
    endfunction

    task automatic fill(input int seed, input int n);
        for (int i = 0; i < n; i++) msg[i] = 8'(seed * 37 + i * 11 + (i >> 2) * 3);
    endtask

    task automatic drive(input logic s, input logic e, input logic [63:0] d, input logic [7:0] m);
        @(negedge clk);
        v = 1'b1; sof = s; eof = e; data = d; en = m;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            v = 1'b0; sof = 1'b0; eof = 1'b0; data = 64'h5A5A_5A5A_5A5A_5A5A; en = 8'h00;
        end
    endtask

    task automatic sample();
        @(posedge clk); #1;
        got_done = done; got_crc = crc; got_err = err;
    endtask

    task automatic send_frame(input int len, input bit junk, input int gap);
        int nb, r;
        logic [63:0] d;
        logic [7:0]  m;
        nb = (len + 7) / 8;
        r  = len - 8 * (nb - 1);
        for (int b = 0; b < nb; b++) begin
            d = '0;
            if (b == 0) begin
                m = 8'hFF << (8 - r);
                for (int l = 0; l < 8; l++)
                    if (l >= 8 - r) d[l*8 +: 8] = msg[l - (8 - r)];
                    else if (junk)  d[l*8 +: 8] = 8'hA5 ^ 8'(l);
            end else begin
                m = 8'hFF;
                for (int l = 0; l < 8; l++) d[l*8 +: 8] = msg[r + 8 * (b - 1) + l];
            end
            drive(b == 0, b == nb - 1, d, m);
            if (b != nb - 1 && gap > 0) idle(gap);
        end
        sample();
        idle(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] exp_a, exp_b, held;
        logic [63:0] da, db;
        string req;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", "crc in reset", crc, 32'h0);
        check("R1", "done in reset", {31'b0, done}, 32'h0);
        check("R1", "err in reset", {31'b0, err}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", "crc after reset", crc, 32'h0);

        // R2: well-known check value, one byte in the first beat
        msg[0] = "1"; msg[1] = "2"; msg[2] = "3"; msg[3] = "4"; msg[4] = "5";
        msg[5] = "6"; msg[6] = "7"; msg[7] = "8"; msg[8] = "9";
        send_frame(9, 1'b1, 0);
        check("R2", "check value done", {31'b0, got_done}, 32'h1);
        check("R2", "check value", got_crc, 32'hCBF43926);

        // table of lengths: R2 full beats, R3 partial first beat, R4 short frames
        for (int t = 0; t < NTAB; t++) begin
            fill(TAB_SEED[t], TAB_LEN[t]);
            send_frame(TAB_LEN[t], t % 2 == 1, t % 3);
            req = (TAB_LEN[t] < 4) ? "R4" : ((TAB_LEN[t] % 8 != 0) ? "R3" : "R2");
            check(req, $sformatf("len %0d done", TAB_LEN[t]), {31'b0, got_done}, 32'h1);
            check(req, $sformatf("len %0d crc", TAB_LEN[t]), got_crc, ref_crc(TAB_LEN[t]));
        end

        // R3: same 14-byte frame with clean and junk lower lanes
        fill(99, 14);
        send_frame(14, 1'b0, 0);
        held = got_crc;
        send_frame(14, 1'b1, 0);
        check("R3", "junk lanes ignored", got_crc, held);

        // R5: result held, done lasts one cycle
        fill(7, 20);
        send_frame(20, 1'b0, 0);
        held = got_crc;
        sample();
        check("R5", "done drops", {31'b0, got_done}, 32'h0);
        idle(3);
        sample();
        check("R5", "crc held", got_crc, held);

        // R6: back-to-back single-beat frames
        fill(201, 8);
        exp_a = ref_crc(8);
        for (int l = 0; l < 8; l++) da[l*8 +: 8] = msg[l];
        fill(202, 8);
        exp_b = ref_crc(8);
        for (int l = 0; l < 8; l++) db[l*8 +: 8] = msg[l];
        drive(1'b1, 1'b1, da, 8'hFF);
        sample();
        check("R6", "first of pair", got_crc, exp_a);
        drive(1'b1, 1'b1, db, 8'hFF);
        sample();
        check("R6", "second of pair", got_crc, exp_b);
        check("R6", "second done", {31'b0, got_done}, 32'h1);
        idle(1);

        // R6: start beat inside an open frame restarts
        drive(1'b1, 1'b0, 64'hDEAD_BEEF_0123_4567, 8'hFF);
        fill(77, 12);
        send_frame(12, 1'b0, 0);
        check("R6", "restart mid-frame", got_crc, ref_crc(12));

        // R7: bad first-beat masks
        drive(1'b1, 1'b0, 64'h1111_2222_3333_4444, 8'b1111_0110);
        sample();
        check("R7", "gap mask err", {31'b0, got_err}, 32'h1);
        check("R7", "gap mask no done", {31'b0, got_done}, 32'h0);
        drive(1'b0, 1'b1, 64'h0, 8'hFF);
        sample();
        check("R7", "dropped frame closes silently", {30'b0, got_done, got_err}, 32'h0);
        drive(1'b1, 1'b1, 64'h0, 8'h0F);
        sample();
        check("R7", "low-lane mask err", {31'b0, got_err}, 32'h1);
        drive(1'b1, 1'b1, 64'h0, 8'h00);
        sample();
        check("R7", "empty mask err", {30'b0, got_done, got_err}, 32'h1);
        idle(1);

        // R8: partial mask on a later beat
        drive(1'b1, 1'b0, 64'h0, 8'hFF);
        drive(1'b0, 1'b1, 64'h0, 8'h7F);
        sample();
        check("R8", "later partial err", {30'b0, got_done, got_err}, 32'h1);
        idle(1);

        // R9: stray beat while idle
        drive(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
        sample();
        check("R9", "stray beat silent", {30'b0, got_done, got_err}, 32'h0);
        fill(55, 27);
        send_frame(27, 1'b1, 2);
        check("R9", "frame with gaps after stray", got_crc, ref_crc(27));

        // R2: random lengths 1..64
        for (int k = 0; k < 30; k++) begin
            int len;
            len = $urandom_range(64, 1);
            for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
            send_frame(len, k % 2 == 0, k % 2);
            check("R2", $sformatf("random len %0d", len), got_crc, ref_crc(len));
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule